// File: doc/BRIEF.md
# Second-Level Interrupt Aggregator

This block gathers a vector of peripheral interrupt requests into a single request line for a parent interrupt controller. Software sees a small word-addressed register window. Through it software reads the pending bits and the per-source disable mask, and it changes that mask through two write-only ports. A bit written as one to the first port disables its source. A bit written as one to the second port enables its source.

A build-time parameter picks one of two variants. In the latched variant, a rising edge on an input records a sticky pending bit. Software acknowledges that bit by writing one to it in an acknowledge register. In the level variant, the pending bits follow the inputs directly, and there is no acknowledge register. The output request is the registered OR of all pending bits whose sources are enabled.

Top module: `irq_aggregator`

## Requirements
- R1: After reset every mask bit reads 1 (all sources disabled), every latched pending bit reads 0 and irq_o is low.
- R2: A write to the mask-set port sets each mask bit whose write-data bit is 1. Mask bits written as 0 are unchanged.
- R3: A write to the mask-clear port clears each mask bit whose write-data bit is 1. Mask bits written as 0 are unchanged.
- R4: Latched variant: a 0-to-1 change of irq_src_i[i] between two clock edges sets pending bit i. The bit stays set after the input falls.
- R5: Latched variant: a write to the acknowledge register clears each pending bit whose write-data bit is 1. If a new edge on a bit arrives in the same cycle as its acknowledge, that bit stays set.
- R6: Level variant: the pending word read at word 0 equals irq_src_i in the same cycle. The variant has no acknowledge register.
- R7: Word-address map, with the byte offset equal to the word address times 4. Latched variant: 0 pending, 2 acknowledge, 3 mask read, 4 mask set, 5 mask clear. Level variant: 0 pending, 1 mask read, 2 mask set, 3 mask clear. Write-only ports read as 0.
- R8: A read of the pending word returns the raw pending bits whatever the mask is. A read of the mask word returns the current mask. rdata_o follows addr_i combinationally.
- R9: irq_o at each clock edge takes the value of the OR of (pending AND NOT mask) just before that edge. It therefore changes one cycle after the pending or mask change that causes it.
- R10: Reads from unmapped word addresses return 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_src_i | input | N_SRC | Peripheral interrupt requests, synchronous to clk_i |
| addr_i | input | ADDR_W | Register word address |
| wdata_i | input | N_SRC | Write data |
| we_i | input | 1 | Write strobe, sampled on the rising clock edge |
| rdata_o | output | N_SRC | Read data for addr_i |
| irq_o | output | 1 | Aggregated request to the parent controller |

## Verification
In the latched variant, a new rising edge on a source and a software acknowledge of that same bit can fall in one cycle. The bench provokes this directly. It raises an input in the very cycle that writes one to that bit's acknowledge position, together with a neighbouring bit that has no new edge. A following read must show the raced bit still pending and the neighbour cleared. Random input toggles mixed with random acknowledge writes then hit the collision many more times. Each such cycle is judged against a bench model that applies the clear first and the edge second.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  typedef struct packed {
    logic pend_rd;
    logic ack_wr;
    logic mask_rd;
    logic mask_set;
    logic mask_clr;
  } reg_sel_t;

  // word-address map per variant
  function automatic reg_sel_t decode_addr(input bit latched, input int unsigned word);
    reg_sel_t s;
    s = '0;
    if (latched) begin
      case (word)
        0: s.pend_rd  = 1'b1;
        2: s.ack_wr   = 1'b1;
        3: s.mask_rd  = 1'b1;
        4: s.mask_set = 1'b1;
        5: s.mask_clr = 1'b1;
        default: ;
      endcase
    end else begin
      case (word)
        0: s.pend_rd  = 1'b1;
        1: s.mask_rd  = 1'b1;
        2: s.mask_set = 1'b1;
        3: s.mask_clr = 1'b1;
        default: ;
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/irq_agg_regmap.sv
module irq_agg_regmap #(
  parameter int ADDR_W  = 4,
  parameter bit LATCHED = 1'b1
) (
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  output irq_agg_pkg::reg_sel_t sel_o,
  output logic                  ack_we_o,
  output logic                  mset_we_o,
  output logic                  mclr_we_o
);
  import irq_agg_pkg::*;

  always_comb begin
    sel_o     = decode_addr(LATCHED, int'(addr_i));
    ack_we_o  = we_i & sel_o.ack_wr;
    mset_we_o = we_i & sel_o.mask_set;
    mclr_we_o = we_i & sel_o.mask_clr;
  end
endmodule

// File: rtl/irq_agg_pending.sv
module irq_agg_pending #(
  parameter int N_SRC   = 32,
  parameter bit LATCHED = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic             ack_we_i,
  input  logic [N_SRC-1:0] ack_data_i,
  output logic [N_SRC-1:0] pend_o
);
  if (LATCHED) begin : g_latched
    logic [N_SRC-1:0] src_q;
    logic [N_SRC-1:0] pend_q;
    logic [N_SRC-1:0] rise;
    logic [N_SRC-1:0] ack;

    assign rise = src_i & ~src_q;
    assign ack  = ack_we_i ? ack_data_i : '0;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        src_q  <= '0;
        pend_q <= '0;
      end else begin
        src_q  <= src_i;
        // edge applied after clear: a racing edge survives
        pend_q <= (pend_q & ~ack) | rise;
      end
    end

    assign pend_o = pend_q;
  end else begin : g_level
    logic unused_level;
    assign unused_level = ^{clk_i, rst_ni, ack_we_i, ack_data_i};
    assign pend_o = src_i;
  end
endmodule

// File: rtl/irq_agg_mask.sv
module irq_agg_mask #(
  parameter int N_SRC = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_we_i,
  input  logic             clr_we_i,
  input  logic [N_SRC-1:0] wdata_i,
  output logic [N_SRC-1:0] mask_o
);
  logic [N_SRC-1:0] mask_q;
  logic [N_SRC-1:0] set_bits;
  logic [N_SRC-1:0] clr_bits;

  assign set_bits = set_we_i ? wdata_i : '0;
  assign clr_bits = clr_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '1;
    else         mask_q <= (mask_q & ~clr_bits) | set_bits;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int N_SRC   = 32,
  parameter int ADDR_W  = 4,
  parameter bit LATCHED = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  irq_src_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_SRC-1:0]  wdata_i,
  input  logic              we_i,
  output logic [N_SRC-1:0]  rdata_o,
  output logic              irq_o
);
  import irq_agg_pkg::*;

  reg_sel_t         sel;
  logic             ack_we;
  logic             mset_we;
  logic             mclr_we;
  logic [N_SRC-1:0] pend_w;
  logic [N_SRC-1:0] mask_w;
  logic             irq_q;

  irq_agg_regmap #(.ADDR_W(ADDR_W), .LATCHED(LATCHED)) i_regmap (
    .we_i      (we_i),
    .addr_i    (addr_i),
    .sel_o     (sel),
    .ack_we_o  (ack_we),
    .mset_we_o (mset_we),
    .mclr_we_o (mclr_we)
  );

  irq_agg_pending #(.N_SRC(N_SRC), .LATCHED(LATCHED)) i_pending (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_i      (irq_src_i),
    .ack_we_i   (ack_we),
    .ack_data_i (wdata_i),
    .pend_o     (pend_w)
  );

  irq_agg_mask #(.N_SRC(N_SRC)) i_mask (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_we_i (mset_we),
    .clr_we_i (mclr_we),
    .wdata_i  (wdata_i),
    .mask_o   (mask_w)
  );

  always_comb begin
    rdata_o = '0;
    if (sel.pend_rd) rdata_o = pend_w;
    if (sel.mask_rd) rdata_o = mask_w;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(pend_w & ~mask_w);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
  parameter int N_SRC   = 32,
  parameter int ADDR_W  = 4,
  parameter bit LATCHED = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_SRC-1:0]  irq_src_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [N_SRC-1:0]  wdata_i,
  input logic              we_i,
  input logic [N_SRC-1:0]  rdata_o,
  input logic              irq_o,
  input logic [N_SRC-1:0]  pend_w,
  input logic [N_SRC-1:0]  mask_w
);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_MRD  = ADDR_W'(LATCHED ? 3 : 1);
  localparam logic [ADDR_W-1:0] A_MSET = ADDR_W'(LATCHED ? 4 : 2);
  localparam logic [ADDR_W-1:0] A_MCLR = ADDR_W'(LATCHED ? 5 : 3);

  logic mset_hit, mclr_hit, mapped, ack_hit;
  logic [N_SRC-1:0] ack_req;
  logic active;

  assign mset_hit = we_i && addr_i == A_MSET;
  assign mclr_hit = we_i && addr_i == A_MCLR;
  assign ack_hit  = LATCHED && we_i && addr_i == A_ACK;
  assign ack_req  = ack_hit ? wdata_i : '0;
  assign mapped   = addr_i == A_PEND || addr_i == A_MRD || addr_i == A_MSET ||
                    addr_i == A_MCLR || (LATCHED && addr_i == A_ACK);
  assign active   = |(pend_w & ~mask_w);

  assert_mask_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mset_hit |=> ((mask_w & $past(wdata_i)) == $past(wdata_i)));

  assert_mask_clr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mclr_hit |=> ((mask_w & $past(wdata_i)) == '0));

  assert_mask_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mset_hit || mclr_hit) |=> $stable(mask_w));

  assert_irq_rise_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active |=> irq_o);

  assert_irq_fall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |=> !irq_o);

  assert_pend_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_PEND) |-> (rdata_o == pend_w));

  assert_mask_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_MRD) |-> (rdata_o == mask_w));

  assert_unmapped_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mapped |-> (rdata_o == '0));

  if (LATCHED) begin : g_latched
    assert_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack_hit || !ack_hit |=> ((($past(pend_w) & ~pend_w) & ~$past(ack_req)) == '0));

    assert_ack_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack_hit |=> ((pend_w & $past(wdata_i & ~irq_src_i)) == '0));
  end else begin : g_level
    assert_follow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pend_w == irq_src_i);
  end
endmodule

bind irq_aggregator irq_aggregator_chk #(
  .N_SRC(N_SRC), .ADDR_W(ADDR_W), .LATCHED(LATCHED)
) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .irq_src_i (irq_src_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .we_i      (we_i),
  .rdata_o   (rdata_o),
  .irq_o     (irq_o),
  .pend_w    (pend_w),
  .mask_w    (mask_w)
);

// File: tb/test_irq_aggregator.sv
`timescale 1ns/1ps
module test_irq_aggregator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        we_l = 1'b0, we_v = 1'b0;
  logic [3:0]  a_l = '0, a_v = '0;
  logic [31:0] wd_l = '0, wd_v = '0;
  logic [31:0] rd_l, rd_v;
  logic        irq_l, irq_v;

  int checks = 0;
  int fails  = 0;

  logic [31:0] m_pend = '0, m_prev = '0, m_lmask = '1, m_vmask = '1;

  always #2.5 clk = ~clk;

  irq_aggregator #(.N_SRC(32), .ADDR_W(4), .LATCHED(1'b1)) i_irq_aggregator (
    .clk_i(clk), .rst_ni(rst_n), .irq_src_i(src), .addr_i(a_l), .wdata_i(wd_l),
    .we_i(we_l), .rdata_o(rd_l), .irq_o(irq_l)
  );

  irq_aggregator #(.N_SRC(32), .ADDR_W(4), .LATCHED(1'b0)) i_irq_aggregator_lvl (
    .clk_i(clk), .rst_ni(rst_n), .irq_src_i(src), .addr_i(a_v), .wdata_i(wd_v),
    .we_i(we_v), .rdata_o(rd_v), .irq_o(irq_v)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string tag_l(input logic [3:0] a);
    case (a)
      4'd0: return "R4";
      4'd3: return "R8";
      4'd2, 4'd4, 4'd5: return "R7";
      default: return "R10";
    endcase
  endfunction

  function automatic string tag_v(input logic [3:0] a);
    case (a)
      4'd0: return "R6";
      4'd1: return "R8";
      4'd2, 4'd3: return "R7";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [31:0] rd_model_l(input logic [3:0] a);
    case (a)
      4'd0: return m_pend;
      4'd3: return m_lmask;
      default: return '0;
    endcase
  endfunction

  function automatic logic [31:0] rd_model_v(input logic [3:0] a, input logic [31:0] s);
    case (a)
      4'd0: return s;
      4'd1: return m_vmask;
      default: return '0;
    endcase
  endfunction

  // one bus cycle on the selected instance; read checked before the edge, irq after
  task automatic step(input logic [31:0] s, input bit lvl, input bit we,
                      input logic [3:0] a, input logic [31:0] wd, input string tag);
    logic [31:0] rise;
    logic ex_il, ex_iv;
    string t;
    @(negedge clk);
    src = s;
    if (lvl) begin
      we_v = we; a_v = a; wd_v = wd; we_l = 1'b0; a_l = '0; wd_l = '0;
    end else begin
      we_l = we; a_l = a; wd_l = wd; we_v = 1'b0; a_v = '0; wd_v = '0;
    end
    #1;
    if (lvl) begin
      t = (tag == "") ? tag_v(a) : tag;
      chk(t, rd_v, rd_model_v(a, s));
    end else begin
      t = (tag == "") ? tag_l(a) : tag;
      chk(t, rd_l, rd_model_l(a));
    end
    ex_il = |(m_pend & ~m_lmask);
    ex_iv = |(s & ~m_vmask);
    rise = s & ~m_prev;
    m_prev = s;
    if (!lvl && we) begin
      case (a)
        4'd2: m_pend  = m_pend & ~wd;
        4'd4: m_lmask = m_lmask | wd;
        4'd5: m_lmask = m_lmask & ~wd;
        default: ;
      endcase
    end
    m_pend = m_pend | rise;
    if (lvl && we) begin
      case (a)
        4'd2: m_vmask = m_vmask | wd;
        4'd3: m_vmask = m_vmask & ~wd;
        default: ;
      endcase
    end
    @(posedge clk);
    #1;
    chk("R9", {31'b0, irq_l}, {31'b0, ex_il});
    chk("R9", {31'b0, irq_v}, {31'b0, ex_iv});
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk("R1", {31'b0, irq_l}, 32'h0);
    chk("R1", {31'b0, irq_v}, 32'h0);
    step(32'h0, 1'b0, 1'b0, 4'd3, 32'h0, "R1");
    step(32'h0, 1'b0, 1'b0, 4'd0, 32'h0, "R1");
    step(32'h0, 1'b1, 1'b0, 4'd1, 32'h0, "R1");

    // R3: unmask low byte
    step(32'h0, 1'b0, 1'b1, 4'd5, 32'h0000_00ff, "R3");
    step(32'h0, 1'b0, 1'b0, 4'd3, 32'h0, "R3");
    chk("R3", m_lmask, 32'hffff_ff00);

    // R4: edge sets sticky bit
    step(32'h1, 1'b0, 1'b0, 4'd0, 32'h0, "R4");
    step(32'h1, 1'b0, 1'b0, 4'd0, 32'h0, "R4");
    step(32'h0, 1'b0, 1'b0, 4'd0, 32'h0, "R4");
    step(32'h0, 1'b0, 1'b0, 4'd0, 32'h0, "R4");

    // R5: ack racing a new edge on bit 1, plain ack on bit 0
    step(32'h2, 1'b0, 1'b1, 4'd2, 32'h3, "R5");
    step(32'h2, 1'b0, 1'b0, 4'd0, 32'h0, "R5");
    chk("R5", rd_l, 32'h2);
    step(32'h2, 1'b0, 1'b1, 4'd2, 32'h2, "R5");
    step(32'h2, 1'b0, 1'b0, 4'd0, 32'h0, "R5");
    chk("R5", rd_l, 32'h0);

    // R10: unmapped write and read
    step(32'h0, 1'b0, 1'b1, 4'd1, 32'hffff_ffff, "R10");
    step(32'h0, 1'b0, 1'b1, 4'd7, 32'hffff_ffff, "R10");
    step(32'h0, 1'b0, 1'b0, 4'd3, 32'h0, "R10");
    step(32'h0, 1'b0, 1'b0, 4'd0, 32'h0, "R10");

    // R2: mask set
    step(32'h0, 1'b0, 1'b1, 4'd4, 32'h0000_000f, "R2");
    step(32'h0, 1'b0, 1'b0, 4'd3, 32'h0, "R2");
    chk("R2", rd_l, 32'hffff_ff0f);

    // R8: masked source still shows pending
    step(32'h8000_0000, 1'b0, 1'b0, 4'd0, 32'h0, "R8");
    step(32'h8000_0000, 1'b0, 1'b0, 4'd0, 32'h0, "R8");
    chk("R8", rd_l, 32'h8000_0000);
    chk("R8", {31'b0, irq_l}, 32'h0);

    // R6/R7: level variant
    step(32'h0, 1'b1, 1'b1, 4'd3, 32'hffff_ffff, "R7");
    step(32'h10, 1'b1, 1'b0, 4'd0, 32'h0, "R6");
    step(32'h10, 1'b1, 1'b1, 4'd2, 32'h10, "R7");
    step(32'h10, 1'b1, 1'b0, 4'd1, 32'h0, "R7");
    chk("R7", rd_v, 32'h0000_0010);
    step(32'h10, 1'b1, 1'b0, 4'd5, 32'h0, "R10");

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] s;
      s = src ^ ($urandom() & $urandom() & $urandom());
      step(s, 1'($urandom() % 2), 1'($urandom() % 2), 4'($urandom() % 8),
           $urandom() & $urandom(), "");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule